// File: doc/BRIEF.md
# Eight-Channel PWM Generator with Pair Joining

The block produces eight pulse-width modulated outputs from a single bus clock. Every channel owns a private counter plus an active period and duty value. Software writes buffer copies of these values through a byte-wide write port. Each channel picks one of four tick sources. Two of them come from power-of-two prescalers, called A and B. The other two, SA and SB, divide A and B further by a programmable integer.

A channel counts in one of two ways. In left-aligned mode it counts upward and wraps. In center-aligned mode it counts up and then back down. Each channel can invert its output. Two neighbouring channels can be merged into one channel with a 16-bit period and duty.

An external trip input can force every output to a programmed safe level. The outputs stay at that level until software issues a restart. The trip input only has this effect while the trip function is armed.

Each channel engine runs a three-state machine:
- OFF: the channel is disabled.
- UP: the counter is incrementing.
- DOWN: the counter is decrementing, which happens only in center-aligned mode.

The transitions are:
- OFF→UP when the channel is enabled.
- UP→UP at the wrap in left-aligned mode.
- UP→DOWN on reaching the top in center mode.
- DOWN→UP on reaching zero.
- Any state→OFF when the channel is disabled.

The trip logic has two states, RUN and HALT:
- RUN→HALT when the trip is armed and the trip input is high.
- HALT→RUN on a restart request while the trip input is low.

Top module: `pwm_multichan`

## Requirements
- R1: After reset every output is low, and all configuration registers are zero.
- R2: In left-aligned mode a channel with period P (P ≥ 1) and duty D repeats every P ticks. It is in its active phase for min(D,P) of those ticks. The period buffer of channel c is at address 16+c and the duty buffer at 24+c. The enable register is at address 0, with bit c for channel c.
- R3: When bit c of the register at address 2 is set, channel c is center-aligned. Its period is 2·P ticks, of which 2·min(D,P) are active.
- R4: Each channel selects its tick with two bits. Channels 0–3 use address 4 and channels 4–7 use address 5, with channel c at bits 2·(c mod 4). The codes are 0=A, 1=B, 2=SA, 3=SB. Address 6 holds the A exponent in bits [2:0] and the B exponent in bits [6:4]; a tick then lasts 2^exponent bus cycles. Addresses 7 and 8 divide A and B again by N, where N=0 means 256.
- R5: When bit c at address 1 is clear, the active phase drives the pin high. When the bit is set, the pin is inverted.
- R6: A period or duty buffer written while its channel runs takes effect only after the current period ends.
- R7: A disabled channel holds its pin at its inversion bit. While disabled, its buffers copy into the active values every cycle.
- R8: Setting bit k at address 3 joins channels 2k and 2k+1. The joined channel uses the 16-bit period {period[2k+1], period[2k]} and duty {duty[2k+1], duty[2k]}. It also takes the enable, tick, mode and inversion of channel 2k+1 and drives pin 2k+1. Pin 2k then stays at the inversion bit of channel 2k.
- R9: The trip control register is at address 9. Bit 0 arms the trip and bit 1 is the safe level. With the trip armed, a high trip input drives every pin to the safe level from the next cycle.
- R10: After a trip, the pins keep the safe level until address 9 is written with bit 2 set while the trip input is low. A restart written while the input is still high is ignored.
- R11: While bit 0 of address 9 is clear, the trip input has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 5 | register address |
| cfg_wdata | input | 8 | register write data |
| trip_in | input | 1 | emergency shutdown request, active high |
| pwm_out | output | 8 | PWM pins, bit c for channel c |

## Verification
The assertions check the following on every cycle:
- the counter never reaches the active period;
- a center-aligned count falls by exactly one per tick on the way down;
- the active period and duty values never change except at a period end or while the channel is disabled;
- the trip state machine enters HALT, stays in HALT and stays in RUN exactly as R9–R11 require.

Only the bench scenarios can show the observable pulse shapes. These are the active-cycle counts per period for each mode, tick source and inversion. The bench also shows that a buffered write is deferred until the period ends. Finally, it shows the pin levels produced by pair joining and by shutdown.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        ENG_OFF  = 2'd0,
        ENG_UP   = 2'd1,
        ENG_DOWN = 2'd2
    } eng_state_t;

    typedef enum logic {
        SD_RUN  = 1'b0,
        SD_HALT = 1'b1
    } sd_state_t;

    typedef enum logic [1:0] {
        SRC_A  = 2'd0,
        SRC_B  = 2'd1,
        SRC_SA = 2'd2,
        SRC_SB = 2'd3
    } clk_src_t;

    localparam int A_EN   = 0;
    localparam int A_INV  = 1;
    localparam int A_CTR  = 2;
    localparam int A_JOIN = 3;
    localparam int A_SEL  = 4;
    localparam int A_PRE  = 6;
    localparam int A_DSA  = 7;
    localparam int A_DSB  = 8;
    localparam int A_SHD  = 9;
    localparam int A_PER  = 16;
    localparam int A_DUTY = 24;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int CH_W   = 8,
    parameter int EXP_W  = 3,
    parameter int ADDR_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [CH_W-1:0]            wdata,
    output logic [N_CH-1:0]            ch_en,
    output logic [N_CH-1:0]            ch_inv,
    output logic [N_CH-1:0]            ch_center,
    output logic [N_CH/2-1:0]          pair_join,
    output logic [N_CH-1:0][1:0]       ch_sel,
    output logic [EXP_W-1:0]           exp_a,
    output logic [EXP_W-1:0]           exp_b,
    output logic [CH_W-1:0]            div_sa,
    output logic [CH_W-1:0]            div_sb,
    output logic                       sd_arm,
    output logic                       sd_idle,
    output logic                       sd_restart,
    output logic [N_CH-1:0][CH_W-1:0]  per_buf,
    output logic [N_CH-1:0][CH_W-1:0]  duty_buf
);

    localparam int N_PAIR = N_CH / 2;
    localparam int B_LSB  = CH_W / 2;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
        return a == ADDR_W'(target);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_en     <= '0;
            ch_inv    <= '0;
            ch_center <= '0;
            pair_join <= '0;
            ch_sel    <= '0;
            exp_a     <= '0;
            exp_b     <= '0;
            div_sa    <= '0;
            div_sb    <= '0;
            sd_arm    <= 1'b0;
            sd_idle   <= 1'b0;
            per_buf   <= '0;
            duty_buf  <= '0;
        end else if (we) begin
            if (hit(addr, A_EN))   ch_en     <= wdata[N_CH-1:0];
            if (hit(addr, A_INV))  ch_inv    <= wdata[N_CH-1:0];
            if (hit(addr, A_CTR))  ch_center <= wdata[N_CH-1:0];
            if (hit(addr, A_JOIN)) pair_join <= wdata[N_PAIR-1:0];
            if (hit(addr, A_PRE)) begin
                exp_a <= wdata[EXP_W-1:0];
                exp_b <= wdata[B_LSB +: EXP_W];
            end
            if (hit(addr, A_DSA)) div_sa <= wdata;
            if (hit(addr, A_DSB)) div_sb <= wdata;
            if (hit(addr, A_SHD)) begin
                sd_arm  <= wdata[0];
                sd_idle <= wdata[1];
            end
            for (int c = 0; c < N_CH; c++) begin
                if (hit(addr, A_SEL + c / 4)) ch_sel[c]   <= wdata[2*(c%4) +: 2];
                if (hit(addr, A_PER + c))     per_buf[c]  <= wdata;
                if (hit(addr, A_DUTY + c))    duty_buf[c] <= wdata;
            end
        end
    end

    // restart is a write pulse, not a stored bit
    assign sd_restart = we && hit(addr, A_SHD) && wdata[2];

endmodule

// File: rtl/pwm_clkgen.sv
module pwm_clkgen
    import pwm_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    input  logic [CH_W-1:0]  div_sa,
    input  logic [CH_W-1:0]  div_sb,
    output logic [3:0]       src_tick
);

    localparam int PRE_W = 2 ** EXP_W;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] mask_a, mask_b;
    logic [1:0]       base_tick;
    logic [1:0]       scaled_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_cnt <= '0;
        else        pre_cnt <= pre_cnt + 1'b1;
    end

    assign mask_a = PRE_W'((1 << exp_a) - 1);
    assign mask_b = PRE_W'((1 << exp_b) - 1);
    assign base_tick[0] = (pre_cnt & mask_a) == mask_a;
    assign base_tick[1] = (pre_cnt & mask_b) == mask_b;

    // second-stage dividers: SA from A, SB from B
    for (genvar k = 0; k < 2; k++) begin : g_scale
        logic [CH_W-1:0] sc_cnt;
        logic [CH_W:0]   lim;
        logic            wrap;
        logic [CH_W-1:0] dv;

        assign dv   = (k == 0) ? div_sa : div_sb;
        assign lim  = (dv == '0) ? (CH_W+1)'(1 << CH_W) : {1'b0, dv};
        assign wrap = {1'b0, sc_cnt} >= (lim - 1'b1);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            sc_cnt <= '0;
            else if (base_tick[k]) sc_cnt <= wrap ? '0 : sc_cnt + 1'b1;
        end

        assign scaled_tick[k] = base_tick[k] && wrap;
    end

    assign src_tick[SRC_A]  = base_tick[0];
    assign src_tick[SRC_B]  = base_tick[1];
    assign src_tick[SRC_SA] = scaled_tick[0];
    assign src_tick[SRC_SB] = scaled_tick[1];

endmodule

// File: rtl/pwm_engine.sv
module pwm_engine
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         center,
    input  logic         inv,
    input  logic [W-1:0] per_buf,
    input  logic [W-1:0] duty_buf,
    output logic         pin
);

    eng_state_t state;
    logic [W-1:0] cnt, per_act, duty_act;
    logic top_reached, period_end;

    assign top_reached = (per_act == '0) || (cnt == per_act - 1'b1);
    assign period_end  = tick && (((state == ENG_UP) && top_reached && !center) ||
                                  ((state == ENG_DOWN) && (cnt == '0)));

    // state register and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ENG_OFF;
            cnt      <= '0;
            per_act  <= '0;
            duty_act <= '0;
        end else if (!en) begin
            state    <= ENG_OFF;
            cnt      <= '0;
            per_act  <= per_buf;
            duty_act <= duty_buf;
        end else begin
            unique case (state)
                ENG_OFF: begin
                    state    <= ENG_UP;
                    cnt      <= '0;
                    per_act  <= per_buf;
                    duty_act <= duty_buf;
                end
                ENG_UP: begin
                    if (tick) begin
                        if (!top_reached) begin
                            cnt <= cnt + 1'b1;
                        end else if (center) begin
                            state <= ENG_DOWN;
                        end else begin
                            cnt      <= '0;
                            per_act  <= per_buf;
                            duty_act <= duty_buf;
                        end
                    end
                end
                ENG_DOWN: begin
                    if (tick) begin
                        if (cnt == '0) begin
                            state    <= ENG_UP;
                            per_act  <= per_buf;
                            duty_act <= duty_buf;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                default: state <= ENG_OFF;
            endcase
        end
    end

    // output process
    always_comb begin
        pin = inv;
        if (state != ENG_OFF && cnt < duty_act) pin = ~inv;
    end

    p_cnt_below_per_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ENG_OFF && per_act != '0) |-> (cnt < per_act));

    p_down_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ENG_DOWN && tick && cnt != '0) |=> (cnt == W'($past(cnt) - 1'b1)));

    p_buffer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state != ENG_OFF && !period_end) |=> ($stable(per_act) && $stable(duty_act)));

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            join_en,
    input  logic [1:0]      en,
    input  logic [1:0]      tick,
    input  logic [1:0]      center,
    input  logic [1:0]      inv,
    input  logic [CH_W-1:0] per_lo,
    input  logic [CH_W-1:0] per_hi,
    input  logic [CH_W-1:0] duty_lo,
    input  logic [CH_W-1:0] duty_hi,
    output logic [1:0]      pins
);

    localparam int WIDE = 2 * CH_W;

    logic [WIDE-1:0] hi_per, hi_duty;
    logic            lo_pin, hi_pin;

    assign hi_per  = join_en ? {per_hi, per_lo}   : {{CH_W{1'b0}}, per_hi};
    assign hi_duty = join_en ? {duty_hi, duty_lo} : {{CH_W{1'b0}}, duty_hi};

    pwm_engine #(.W(CH_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .en(en[0] && !join_en), .tick(tick[0]),
        .center(center[0]), .inv(inv[0]), .per_buf(per_lo), .duty_buf(duty_lo),
        .pin(lo_pin)
    );

    pwm_engine #(.W(WIDE)) u_hi (
        .clk(clk), .rst_n(rst_n), .en(en[1]), .tick(tick[1]),
        .center(center[1]), .inv(inv[1]), .per_buf(hi_per), .duty_buf(hi_duty),
        .pin(hi_pin)
    );

    assign pins[0] = join_en ? inv[0] : lo_pin;
    assign pins[1] = hi_pin;

endmodule

// File: rtl/pwm_shutdown.sv
module pwm_shutdown
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic trip_in,
    input  logic restart,
    output logic halted
);

    sd_state_t state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SD_RUN;
        end else begin
            unique case (state)
                SD_RUN:  if (arm && trip_in)     state <= SD_HALT;
                SD_HALT: if (restart && !trip_in) state <= SD_RUN;
                default: state <= SD_RUN;
            endcase
        end
    end

    always_comb halted = (state == SD_HALT);

    p_trip_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && trip_in) |=> halted);

    p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !(restart && !trip_in)) |=> halted);

    p_unarmed_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !arm) |=> !halted);

endmodule

// File: rtl/pwm_multichan.sv
module pwm_multichan
    import pwm_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int CH_W   = 8,
    parameter int EXP_W  = 3,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CH_W-1:0]   cfg_wdata,
    input  logic              trip_in,
    output logic [N_CH-1:0]   pwm_out
);

    localparam int N_PAIR = N_CH / 2;

    logic [N_CH-1:0]           ch_en, ch_inv, ch_center, ch_tick;
    logic [N_PAIR-1:0]         pair_join;
    logic [N_CH-1:0][1:0]      ch_sel;
    logic [EXP_W-1:0]          exp_a, exp_b;
    logic [CH_W-1:0]           div_sa, div_sb;
    logic                      sd_arm, sd_idle, sd_restart, halted;
    logic [N_CH-1:0][CH_W-1:0] per_buf, duty_buf;
    logic [3:0]                src_tick;
    logic [N_CH-1:0]           raw_pin;

    pwm_regs #(.N_CH(N_CH), .CH_W(CH_W), .EXP_W(EXP_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ch_en(ch_en), .ch_inv(ch_inv), .ch_center(ch_center), .pair_join(pair_join),
        .ch_sel(ch_sel), .exp_a(exp_a), .exp_b(exp_b), .div_sa(div_sa), .div_sb(div_sb),
        .sd_arm(sd_arm), .sd_idle(sd_idle), .sd_restart(sd_restart),
        .per_buf(per_buf), .duty_buf(duty_buf)
    );

    pwm_clkgen #(.CH_W(CH_W), .EXP_W(EXP_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .exp_a(exp_a), .exp_b(exp_b),
        .div_sa(div_sa), .div_sb(div_sb), .src_tick(src_tick)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_sel
        assign ch_tick[c] = src_tick[ch_sel[c]];
    end

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        pwm_pair #(.CH_W(CH_W)) u_pair (
            .clk(clk), .rst_n(rst_n), .join_en(pair_join[p]),
            .en(ch_en[2*p +: 2]), .tick(ch_tick[2*p +: 2]),
            .center(ch_center[2*p +: 2]), .inv(ch_inv[2*p +: 2]),
            .per_lo(per_buf[2*p]), .per_hi(per_buf[2*p+1]),
            .duty_lo(duty_buf[2*p]), .duty_hi(duty_buf[2*p+1]),
            .pins(raw_pin[2*p +: 2])
        );
    end

    pwm_shutdown u_sd (
        .clk(clk), .rst_n(rst_n), .arm(sd_arm), .trip_in(trip_in),
        .restart(sd_restart), .halted(halted)
    );

    assign pwm_out = halted ? {N_CH{sd_idle}} : raw_pin;

    p_trip_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_arm && trip_in) |=> (pwm_out == {N_CH{$past(sd_idle)}}));

endmodule

// File: tb/pwm_multichan_tb.sv
module pwm_multichan_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       trip_in = 1'b0;
    logic [7:0] pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  en_sh = '0, inv_sh = '0, ctr_sh = '0;
    logic [15:0] sel_sh = '0;

    pwm_multichan dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .trip_in(trip_in), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int div_of(input int sel, input int pa, input int pb,
                                  input int na, input int nb);
        case (sel)
            0: return 1 << pa;
            1: return 1 << pb;
            2: return (1 << pa) * (na == 0 ? 256 : na);
            default: return (1 << pb) * (nb == 0 ? 256 : nb);
        endcase
    endfunction

    function automatic int per_ticks(input int p, input bit ctr);
        return ctr ? 2 * p : p;
    endfunction

    function automatic int act_ticks(input int p, input int d, input bit ctr);
        int m = (d < p) ? d : p;
        return ctr ? 2 * m : m;
    endfunction

    task automatic setup(input int ch, input int p, input int d, input bit ctr,
                         input bit inv, input int sel);
        en_sh[ch] = 1'b0;  wr(0, en_sh);
        wr(16 + ch, p);
        wr(24 + ch, d);
        inv_sh[ch] = inv;  wr(1, inv_sh);
        ctr_sh[ch] = ctr;  wr(2, ctr_sh);
        sel_sh[2*ch +: 2] = 2'(sel);
        wr(4 + ch / 4, sel_sh[8*(ch/4) +: 8]);
        en_sh[ch] = 1'b1;  wr(0, en_sh);
    endtask

    task automatic measure(input int ch, input bit lvl, input int len, output int n);
        n = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pwm_out[ch] == lvl) n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, per, div, ch, p, d, sel, pa, pb, na, nb, seed;
        bit ctr, inv;
        seed = $urandom(32'd4021);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwm_out == 8'h00, "R1 reset outputs", pwm_out, 0);

        // R7: disabled pin follows its inversion bit
        inv_sh = 8'h20; wr(1, inv_sh);
        chk(pwm_out == 8'h20, "R7 disabled idle level", pwm_out, 32);
        inv_sh = 8'h00; wr(1, inv_sh);

        // R2: left aligned on A (exponent 0)
        wr(6, 8'h10);   // A exp 0, B exp 1
        wr(7, 3); wr(8, 2);
        setup(1, 10, 3, 1'b0, 1'b0, 0);
        repeat (12) @(negedge clk);
        measure(1, 1'b1, 20, n);
        chk(n == 6, "R2 left aligned active count", n, 6);

        // R3 and R4: center aligned on B (div 2)
        setup(4, 6, 2, 1'b1, 1'b0, 1);
        repeat (30) @(negedge clk);
        measure(4, 1'b1, 48, n);
        chk(n == 16, "R3 R4 center aligned on B", n, 16);

        // R4: SA = A/3, duty above period gives full active
        setup(6, 4, 9, 1'b0, 1'b0, 2);
        repeat (20) @(negedge clk);
        measure(6, 1'b1, 24, n);
        chk(n == 24, "R4 SA source duty over period", n, 24);

        // R2: zero duty
        setup(7, 5, 0, 1'b0, 1'b0, 3);
        repeat (12) @(negedge clk);
        measure(7, 1'b1, 40, n);
        chk(n == 0, "R2 zero duty", n, 0);

        // R5: inverted output, active phase is low
        setup(3, 8, 2, 1'b0, 1'b1, 0);
        repeat (10) @(negedge clk);
        measure(3, 1'b0, 16, n);
        chk(n == 4, "R5 inverted active phase", n, 4);

        // R6: duty rewrite while running is deferred
        setup(0, 50, 40, 1'b0, 1'b0, 0);
        repeat (5) @(negedge clk);
        wr(24, 0);
        repeat (3) @(negedge clk);
        chk(pwm_out[0] == 1'b1, "R6 old duty still active", pwm_out[0], 1);
        repeat (60) @(negedge clk);
        measure(0, 1'b1, 50, n);
        chk(n == 0, "R6 new duty after period end", n, 0);

        // R8: join channels 2 and 3, period 300 duty 100
        en_sh[3] = 1'b0; wr(0, en_sh);
        wr(3, 8'h02);
        wr(16 + 2, 8'h2C); wr(16 + 3, 8'h01);
        wr(24 + 2, 8'h64); wr(24 + 3, 8'h00);
        inv_sh[3] = 1'b0; inv_sh[2] = 1'b0; wr(1, inv_sh);
        ctr_sh[3] = 1'b0; wr(2, ctr_sh);
        sel_sh[7:4] = 4'b0000; wr(4, sel_sh[7:0]);
        en_sh[3:2] = 2'b11; wr(0, en_sh);
        repeat (10) @(negedge clk);
        measure(3, 1'b1, 600, n);
        chk(n == 200, "R8 joined 16-bit active count", n, 200);
        measure(2, 1'b1, 300, n);
        chk(n == 0, "R8 low pin of joined pair idle", n, 0);
        wr(3, 0);

        // R11: unarmed trip ignored
        setup(0, 10, 5, 1'b0, 1'b0, 0);
        wr(9, 8'h02);
        repeat (12) @(negedge clk);
        trip_in = 1'b1;
        measure(0, 1'b1, 20, n);
        chk(n == 10, "R11 trip ignored while unarmed", n, 10);
        trip_in = 1'b0;

        // R9: armed trip forces safe level 1
        wr(9, 8'h03);
        trip_in = 1'b1;
        @(negedge clk);
        chk(pwm_out == 8'hFF, "R9 trip drives safe level", pwm_out, 255);

        // R10: restart while trip high ignored; no restart keeps halt
        wr(9, 8'h07);
        repeat (2) @(negedge clk);
        chk(pwm_out == 8'hFF, "R10 restart ignored with trip high", pwm_out, 255);
        trip_in = 1'b0;
        repeat (5) @(negedge clk);
        chk(pwm_out == 8'hFF, "R10 halt held without restart", pwm_out, 255);
        wr(9, 8'h07);
        repeat (12) @(negedge clk);
        measure(0, 1'b1, 20, n);
        chk(n == 10, "R10 normal output after restart", n, 10);
        wr(9, 0);

        // random configurations
        for (int it = 0; it < 8; it++) begin
            ch  = $urandom_range(0, 7);
            p   = $urandom_range(2, 20);
            d   = $urandom_range(0, p + 2);
            ctr = 1'($urandom_range(0, 1));
            inv = 1'($urandom_range(0, 1));
            sel = $urandom_range(0, 3);
            pa  = $urandom_range(0, 2);
            pb  = $urandom_range(0, 2);
            na  = $urandom_range(1, 3);
            nb  = $urandom_range(1, 3);
            wr(6, (pb << 4) | pa);
            wr(7, na); wr(8, nb);
            setup(ch, p, d, ctr, inv, sel);
            div = div_of(sel, pa, pb, na, nb);
            per = per_ticks(p, ctr) * div;
            repeat (per + 8) @(negedge clk);
            measure(ch, ~inv, 2 * per, n);
            chk(n == 2 * act_ticks(p, d, ctr) * div,
                "R2 R3 R4 R5 random configuration", n, 2 * act_ticks(p, d, ctr) * div);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule